// File: doc/BRIEF.md
# Paged Host Register File for an Ethernet Controller

This block is the byte-wide register front end a host processor uses to program and supervise a simple Ethernet controller. The host sees 16 byte addresses. Address 0 is the command register at all times; every other address is resolved against a register bank picked by the top two command bits, so the same address can reach ring pointers, station address bytes, hash filter bytes or fixed identification values depending on the selected page.

The block keeps the ring page pointers, the transmit page and length, the remote address and count, the receive and data configuration bytes, the station address, the multicast hash, the interrupt mask and an interrupt status byte. It drives one level-sensitive interrupt line. Writing the command register with the transmit bit set, while the controller is not stopped, hands the transmit page and length to the transmit-request outputs as a one-cycle pulse and marks the transmit as complete at once. Status bits from the receive side arrive on an event input; the MAC, the packet memory and the bus wrapper live outside the block.

Reads are combinational from the address and the registered state; writes take effect at the clock edge that samples `wr_en`.

Top module: `pnic_host_regs`

## Requirements
- R1: Host address 0 reads and writes the command register whatever the page. Every other address resolves to the effective offset page*16 + address, where page is command bits 7:6. Command bits: stop 0x01, start 0x02, transmit 0x04, remote read 0x08, remote write 0x10, no-DMA 0x20.
- R2: On page 1, offsets 0x11..0x16 hold the station address bytes, 0x17 the current ring page and 0x18..0x1F the hash bytes, all written and read back there. A write on one page never alters a register reached through another page.
- R3: Page-0 writes to offsets 0x01 and 0x02 set the ring start and stop pages; `ring_start_addr` and `ring_stop_addr` show each page times 256, and page-2 reads of offsets 0x21 and 0x22 return the page values. Writes to any address other than 0 on pages 2 and 3 are ignored.
- R4: Page-0 offsets 0x0A and 0x0B read 0x50 and 0x43; page-3 offsets 0x35 and 0x36 read 0x40; offset 0x33 and every unmapped offset read 0. Page-0 readable registers: 0x03 boundary, 0x04 transmit status, 0x07 interrupt status, 0x08/0x09 remote address low/high.
- R5: The 16-bit transmit length (page-0 0x05 low, 0x06 high), remote address (0x08, 0x09) and remote count (0x0A, 0x0B) are written a byte at a time; each write replaces only its own byte.
- R6: `irq` is high exactly when (status AND mask AND 0x7F) is nonzero; the mask is written at page-0 offset 0x0F. Status bit 7 never raises `irq`.
- R7: A write to page-0 offset 0x07 clears each status bit 6:0 written as one; bit 7 is not cleared by it. Status bits: receive 0x01, transmit 0x02, receive error 0x04, transmit error 0x08, overwrite 0x10, counter 0x20, remote-DMA done 0x40, reset 0x80. A bit set by `evt_set` in the same cycle as its clear stays set.
- R8: A command write with the stop bit clear clears status bit 7; a command write with stop set leaves it.
- R9: A command write with stop clear that requests remote read or remote write while the 16-bit remote count is zero sets status bit 6.
- R10: A command write with stop clear and transmit set gives, one edge later, a one-cycle `tx_req` with `tx_addr` = transmit page*256 and `tx_len` = the 16-bit length; transmit status (page-0 0x04) becomes 0x01, status bit 1 is set, and the stored command has its transmit bit cleared.
- R11: A command write with stop set produces no transmit request and no status change, and the command reads back exactly as written.
- R12: After reset the command register is 0x01, the status register 0x80, and the mask, pointers, counts, configuration bytes and transmit outputs are 0.
- R13: Page-0 writes to offsets 0x0C and 0x0E appear on `rx_cfg` and `dma_cfg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Host write strobe, sampled at the clock edge |
| addr | input | 4 | Host byte address |
| wdata | input | 8 | Host write data |
| evt_set | input | 7 | Status bits 6:0 to set this cycle, from the receive side |
| rdata | output | 8 | Host read data for `addr` on the current page |
| irq | output | 1 | Level interrupt request |
| tx_req | output | 1 | One-cycle transmit request |
| tx_addr | output | 16 | Packet memory byte address of the frame to send |
| tx_len | output | 16 | Frame length in bytes |
| ring_start_addr | output | 16 | Receive ring start byte address |
| ring_stop_addr | output | 16 | Receive ring stop byte address |
| rx_cfg | output | 8 | Receive configuration byte |
| dma_cfg | output | 8 | Data configuration byte |

## Verification
Assertions watch every cycle that a write of ones to the status register leaves those bits clear unless an event set them, that the reset status bit only falls on a running command write and never rises outside reset, that a masked-off status byte keeps the line low, and that a transmit command yields the pulse with the length and page captured before it while a stopped command yields none. The page-dependent address map, fixed identification and configuration bytes, the byte-lane behaviour of the 16-bit registers and the zero-count test behind the DMA-done bit are only visible through the bench's write-then-read scenarios, which also cover the event-versus-clear collision and a second reset.

// File: rtl/pnic_pkg.sv
package pnic_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned HOST_AW = 4;
  localparam int unsigned OFF_W   = HOST_AW + 2;
  localparam int unsigned WORD_W  = 2 * BYTE_W;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [OFF_W-1:0]  off_t;
  typedef logic [WORD_W-1:0] word_t;

  // command bit positions
  localparam int unsigned CMD_STOP   = 0;
  localparam int unsigned CMD_TRANS  = 2;
  localparam int unsigned CMD_RREAD  = 3;
  localparam int unsigned CMD_RWRITE = 4;

  // status bit positions
  localparam int unsigned ST_TX  = 1;
  localparam int unsigned ST_RDC = 6;
  localparam int unsigned ST_RST = 7;

  // effective offsets: {page, host address}
  localparam off_t OFF_RSTART = 6'h01;
  localparam off_t OFF_RSTOP  = 6'h02;
  localparam off_t OFF_BND    = 6'h03;
  localparam off_t OFF_TPAGE  = 6'h04;
  localparam off_t OFF_TLEN_L = 6'h05;
  localparam off_t OFF_TLEN_H = 6'h06;
  localparam off_t OFF_STAT   = 6'h07;
  localparam off_t OFF_RADR_L = 6'h08;
  localparam off_t OFF_RADR_H = 6'h09;
  localparam off_t OFF_RCNT_L = 6'h0A;
  localparam off_t OFF_RCNT_H = 6'h0B;
  localparam off_t OFF_RXCFG  = 6'h0C;
  localparam off_t OFF_DMACFG = 6'h0E;
  localparam off_t OFF_MASK   = 6'h0F;
  localparam off_t OFF_STA0   = 6'h11;
  localparam off_t OFF_CURPG  = 6'h17;
  localparam off_t OFF_HASH0  = 6'h18;
  localparam off_t OFF_P2_RS  = 6'h21;
  localparam off_t OFF_P2_RE  = 6'h22;
  localparam off_t OFF_P3_C2  = 6'h35;
  localparam off_t OFF_P3_C3  = 6'h36;

  localparam byte_t ID_LO_VAL = 8'h50;
  localparam byte_t ID_HI_VAL = 8'h43;
  localparam byte_t P3_VAL    = 8'h40;
  localparam byte_t CMD_RST   = 8'h01;
  localparam byte_t STAT_RST  = 8'h80;
  localparam byte_t TSR_DONE  = 8'h01;

  function automatic off_t eff_offset(input byte_t cmd, input logic [HOST_AW-1:0] a);
    return {cmd[BYTE_W-1 -: 2], a};
  endfunction

  function automatic word_t page_to_addr(input byte_t pg);
    return {pg, {BYTE_W{1'b0}}};
  endfunction

  function automatic word_t put_lane(input word_t w, input logic hi, input byte_t b);
    return hi ? {b, w[BYTE_W-1:0]} : {w[WORD_W-1:BYTE_W], b};
  endfunction

  function automatic logic irq_level(input byte_t st, input byte_t mk);
    return |(st & mk & 8'h7F);
  endfunction

  function automatic byte_t stat_step(input byte_t cur, input byte_t clr, input byte_t set);
    return (cur & ~clr) | set;
  endfunction
endpackage

// File: rtl/pnic_decode.sv
module pnic_decode
  import pnic_pkg::*;
(
  input  byte_t                cmd_q,
  input  logic [HOST_AW-1:0]   addr,
  input  logic                 wr_en,
  output off_t                 off,
  output logic                 cmd_wr,
  output logic                 reg_wr
);
  always_comb begin
    off    = eff_offset(cmd_q, addr);
    cmd_wr = wr_en && (addr == '0);
    reg_wr = wr_en && (addr != '0);
  end
endmodule

// File: rtl/pnic_intctl.sv
module pnic_intctl
  import pnic_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr_wr,
  input  logic [6:0] clr_bits,
  input  logic       mask_wr,
  input  byte_t      mask_val,
  input  logic       rst_bit_clr,
  input  logic [6:0] set_bits,
  output byte_t      stat_q,
  output logic       irq
);
  byte_t mask_q;
  byte_t clr_vec;
  byte_t set_vec;

  always_comb begin
    clr_vec = clr_wr ? {1'b0, clr_bits} : '0;
    clr_vec[ST_RST] = rst_bit_clr;
    set_vec = {1'b0, set_bits};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= STAT_RST;
      mask_q <= '0;
    end else begin
      stat_q <= stat_step(stat_q, clr_vec, set_vec);
      if (mask_wr) mask_q <= mask_val;
    end
  end

  assign irq = irq_level(stat_q, mask_q);

  // R7: ones written clear their bits unless an event sets them together
  p_clear_ones_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> ((stat_q[6:0] & $past(clr_bits & ~set_bits)) == 7'd0));

  // R7: the reset bit survives everything except a running command write
  p_rstbit_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q[ST_RST] && !rst_bit_clr) |=> stat_q[ST_RST]);

  // R8: a running command write drops the reset bit
  p_rstbit_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_bit_clr |=> !stat_q[ST_RST]);

  // R12: the reset bit is only ever set by reset
  p_rstbit_no_rise_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(stat_q[ST_RST]));

  // R6: an empty low mask keeps the line low
  p_mask_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q[6:0] == 7'd0) |-> !irq);
endmodule

// File: rtl/pnic_rdmux.sv
module pnic_rdmux
  import pnic_pkg::*;
#(
  parameter int unsigned STA_BYTES  = 6,
  parameter int unsigned HASH_BYTES = 8
) (
  input  off_t                   off,
  input  byte_t                  cmd_q,
  input  byte_t                  rstart_q,
  input  byte_t                  rstop_q,
  input  byte_t                  bnd_q,
  input  byte_t                  tsr_q,
  input  byte_t                  stat_q,
  input  word_t                  radr_q,
  input  byte_t                  curpg_q,
  input  byte_t [STA_BYTES-1:0]  sta_q,
  input  byte_t [HASH_BYTES-1:0] hash_q,
  output byte_t                  rdata
);
  always_comb begin
    rdata = '0;
    unique case (off)
      OFF_BND:    rdata = bnd_q;
      OFF_TPAGE:  rdata = tsr_q;
      OFF_STAT:   rdata = stat_q;
      OFF_RADR_L: rdata = radr_q[BYTE_W-1:0];
      OFF_RADR_H: rdata = radr_q[WORD_W-1:BYTE_W];
      OFF_RCNT_L: rdata = ID_LO_VAL;
      OFF_RCNT_H: rdata = ID_HI_VAL;
      OFF_CURPG:  rdata = curpg_q;
      OFF_P2_RS:  rdata = rstart_q;
      OFF_P2_RE:  rdata = rstop_q;
      OFF_P3_C2:  rdata = P3_VAL;
      OFF_P3_C3:  rdata = P3_VAL;
      default:    rdata = '0;
    endcase
    for (int i = 0; i < int'(STA_BYTES); i++)
      if (off == off_t'(int'(OFF_STA0) + i)) rdata = sta_q[i];
    for (int i = 0; i < int'(HASH_BYTES); i++)
      if (off == off_t'(int'(OFF_HASH0) + i)) rdata = hash_q[i];
    if (off[HOST_AW-1:0] == '0) rdata = cmd_q;
  end
endmodule

// File: rtl/pnic_host_regs.sv
module pnic_host_regs
  import pnic_pkg::*;
#(
  parameter int unsigned STA_BYTES  = 6,
  parameter int unsigned HASH_BYTES = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [3:0]  addr,
  input  logic [7:0]  wdata,
  input  logic [6:0]  evt_set,
  output logic [7:0]  rdata,
  output logic        irq,
  output logic        tx_req,
  output logic [15:0] tx_addr,
  output logic [15:0] tx_len,
  output logic [15:0] ring_start_addr,
  output logic [15:0] ring_stop_addr,
  output logic [7:0]  rx_cfg,
  output logic [7:0]  dma_cfg
);
  byte_t cmd_q, rstart_q, rstop_q, bnd_q, tpage_q, tsr_q, curpg_q, stat_q;
  byte_t rxcfg_q, dmacfg_q;
  word_t tlen_q, radr_q, rcnt_q;
  byte_t [STA_BYTES-1:0]  sta_q;
  byte_t [HASH_BYTES-1:0] hash_q;

  off_t off;
  logic cmd_wr, reg_wr;

  // named internal events
  logic cmd_run, tx_fire, rdc_fire;
  logic [6:0] set_bits;

  pnic_decode u_dec (
    .cmd_q (cmd_q), .addr (addr), .wr_en (wr_en),
    .off (off), .cmd_wr (cmd_wr), .reg_wr (reg_wr)
  );

  always_comb begin
    cmd_run  = cmd_wr && !wdata[CMD_STOP];
    tx_fire  = cmd_run && wdata[CMD_TRANS];
    rdc_fire = cmd_run && (wdata[CMD_RREAD] || wdata[CMD_RWRITE]) && (rcnt_q == '0);
    set_bits = evt_set;
    set_bits[ST_TX]  = set_bits[ST_TX]  | tx_fire;
    set_bits[ST_RDC] = set_bits[ST_RDC] | rdc_fire;
  end

  pnic_intctl u_int (
    .clk (clk), .rst_n (rst_n),
    .clr_wr (reg_wr && off == OFF_STAT), .clr_bits (wdata[6:0]),
    .mask_wr (reg_wr && off == OFF_MASK), .mask_val (wdata),
    .rst_bit_clr (cmd_run), .set_bits (set_bits),
    .stat_q (stat_q), .irq (irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q    <= CMD_RST;
      rstart_q <= '0;
      rstop_q  <= '0;
      bnd_q    <= '0;
      tpage_q  <= '0;
      tsr_q    <= '0;
      curpg_q  <= '0;
      rxcfg_q  <= '0;
      dmacfg_q <= '0;
      tlen_q   <= '0;
      radr_q   <= '0;
      rcnt_q   <= '0;
      tx_req   <= 1'b0;
      tx_addr  <= '0;
      tx_len   <= '0;
    end else begin
      tx_req <= tx_fire;
      if (cmd_wr) begin
        cmd_q <= wdata;
        if (tx_fire) cmd_q[CMD_TRANS] <= 1'b0;
      end
      if (tx_fire) begin
        tx_addr <= page_to_addr(tpage_q);
        tx_len  <= tlen_q;
        tsr_q   <= TSR_DONE;
      end
      if (reg_wr) begin
        unique case (off)
          OFF_RSTART: rstart_q <= wdata;
          OFF_RSTOP:  rstop_q  <= wdata;
          OFF_BND:    bnd_q    <= wdata;
          OFF_TPAGE:  tpage_q  <= wdata;
          OFF_TLEN_L: tlen_q   <= put_lane(tlen_q, 1'b0, wdata);
          OFF_TLEN_H: tlen_q   <= put_lane(tlen_q, 1'b1, wdata);
          OFF_RADR_L: radr_q   <= put_lane(radr_q, 1'b0, wdata);
          OFF_RADR_H: radr_q   <= put_lane(radr_q, 1'b1, wdata);
          OFF_RCNT_L: rcnt_q   <= put_lane(rcnt_q, 1'b0, wdata);
          OFF_RCNT_H: rcnt_q   <= put_lane(rcnt_q, 1'b1, wdata);
          OFF_RXCFG:  rxcfg_q  <= wdata;
          OFF_DMACFG: dmacfg_q <= wdata;
          OFF_CURPG:  curpg_q  <= wdata;
          default: ;
        endcase
      end
    end
  end

  for (genvar g = 0; g < int'(STA_BYTES); g++) begin : g_sta
    localparam off_t SLOT = off_t'(int'(OFF_STA0) + g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sta_q[g] <= '0;
      else if (reg_wr && off == SLOT) sta_q[g] <= wdata;
    end
  end

  for (genvar g = 0; g < int'(HASH_BYTES); g++) begin : g_hash
    localparam off_t SLOT = off_t'(int'(OFF_HASH0) + g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hash_q[g] <= '0;
      else if (reg_wr && off == SLOT) hash_q[g] <= wdata;
    end
  end

  pnic_rdmux #(.STA_BYTES (STA_BYTES), .HASH_BYTES (HASH_BYTES)) u_rd (
    .off (off), .cmd_q (cmd_q), .rstart_q (rstart_q), .rstop_q (rstop_q),
    .bnd_q (bnd_q), .tsr_q (tsr_q), .stat_q (stat_q), .radr_q (radr_q),
    .curpg_q (curpg_q), .sta_q (sta_q), .hash_q (hash_q), .rdata (rdata)
  );

  assign ring_start_addr = page_to_addr(rstart_q);
  assign ring_stop_addr  = page_to_addr(rstop_q);
  assign rx_cfg          = rxcfg_q;
  assign dma_cfg         = dmacfg_q;

  // R10: a running transmit command yields the pulse, the status bit and a cleared command bit
  p_tx_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_fire |=> (tx_req && stat_q[ST_TX] && !cmd_q[CMD_TRANS] && tsr_q == TSR_DONE));

  // R10: the request carries the page and length held before it
  p_tx_fields_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_fire |=> (tx_len == $past(tlen_q) && tx_addr == {$past(tpage_q), 8'h00}));

  // R11: a stopped command never requests a transmit
  p_stop_no_tx_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && wdata[CMD_STOP]) |=> !tx_req);

  // R9: remote request with zero count raises the DMA-done bit
  p_rdc_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rdc_fire |=> stat_q[ST_RDC]);
endmodule

// File: tb/pnic_host_regs_tb.sv
`timescale 1ns/1ps
module pnic_host_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [6:0]  evt_set = '0;
  logic [7:0]  rdata;
  logic        irq, tx_req;
  logic [15:0] tx_addr, tx_len, ring_start_addr, ring_stop_addr;
  logic [7:0]  rx_cfg, dma_cfg;

  always #2 clk = ~clk;

  pnic_host_regs u_dut (
    .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .addr (addr), .wdata (wdata),
    .evt_set (evt_set), .rdata (rdata), .irq (irq), .tx_req (tx_req),
    .tx_addr (tx_addr), .tx_len (tx_len), .ring_start_addr (ring_start_addr),
    .ring_stop_addr (ring_stop_addr), .rx_cfg (rx_cfg), .dma_cfg (dma_cfg)
  );

  // what the monitor samples
  localparam int K_RD = 0, K_IRQ = 1, K_TXREQ = 2, K_TXADR = 3, K_TXLEN = 4,
                 K_RS = 5, K_RE = 6, K_RXC = 7, K_DMAC = 8;

  typedef struct {
    int          kind;
    logic [15:0] exp;
    string       tag;
  } item_t;

  item_t sb[$];
  int checks = 0;
  int failures = 0;
  bit done = 0;

  function automatic logic [15:0] observe(input int k);
    case (k)
      K_RD:    return {8'h00, rdata};
      K_IRQ:   return {15'd0, irq};
      K_TXREQ: return {15'd0, tx_req};
      K_TXADR: return tx_addr;
      K_TXLEN: return tx_len;
      K_RS:    return ring_start_addr;
      K_RE:    return ring_stop_addr;
      K_RXC:   return {8'h00, rx_cfg};
      default: return {8'h00, dma_cfg};
    endcase
  endfunction

  // monitor: compares every queued item at the falling edge
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t it;
      logic [15:0] act;
      it = sb.pop_front();
      act = observe(it.kind);
      checks++;
      if (act !== it.exp) begin
        failures++;
        $display("FAIL %s kind=%0d actual=0x%04h expected=0x%04h", it.tag, it.kind, act, it.exp);
      end
    end
  end

  // driver tasks: each starts and ends 1 ns after a rising edge
  task automatic push(input int k, input logic [15:0] e, input string t);
    item_t it;
    it.kind = k; it.exp = e; it.tag = t;
    sb.push_back(it);
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    step();
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] e, input string t);
    addr = a;
    push(K_RD, {8'h00, e}, t);
    step();
  endtask

  task automatic see(input int k, input logic [15:0] e, input string t);
    push(k, e, t);
    step();
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 1'b0; evt_set = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step();
  endtask

  initial begin
    do_reset();
    // R12 reset values
    rd(4'h0, 8'h01, "R12 command after reset");
    rd(4'h7, 8'h80, "R12 status after reset");
    see(K_IRQ, 16'h0, "R12 irq after reset");
    see(K_RS, 16'h0, "R12 ring start after reset");
    see(K_TXLEN, 16'h0, "R12 tx_len after reset");
    // R6 reset bit cannot raise irq
    wr(4'hF, 8'hFF);
    see(K_IRQ, 16'h0, "R6 reset bit masked from irq");
    wr(4'hF, 8'h00);
    // R8 running command clears reset bit
    wr(4'h0, 8'h22);
    rd(4'h7, 8'h00, "R8 reset bit cleared by running command");
    rd(4'h0, 8'h22, "R1 command readback page0");
    // R2 page 1 registers
    wr(4'h0, 8'h62);
    rd(4'h0, 8'h62, "R1 address 0 is command on page1");
    for (int i = 1; i <= 6; i++) wr(4'(i), 8'(8'h50 + i));
    wr(4'h7, 8'h4C);
    for (int i = 8; i <= 15; i++) wr(4'(i), 8'(8'hA0 + i));
    for (int i = 1; i <= 6; i++) rd(4'(i), 8'(8'h50 + i), "R2 station byte");
    rd(4'h7, 8'h4C, "R2 current page");
    for (int i = 8; i <= 15; i++) rd(4'(i), 8'(8'hA0 + i), "R2 hash byte");
    // R3 ring pointers on page 0
    wr(4'h0, 8'h22);
    wr(4'h1, 8'h46);
    wr(4'h2, 8'h80);
    see(K_RS, 16'h4600, "R3 ring start times 256");
    see(K_RE, 16'h8000, "R3 ring stop times 256");
    rd(4'h1, 8'h00, "R4 page0 offset 1 unmapped read");
    wr(4'h0, 8'h62);
    rd(4'h1, 8'h51, "R2 page0 write left station byte");
    rd(4'h7, 8'h4C, "R2 page0 boundary-area writes left current page");
    wr(4'h0, 8'hA2);
    rd(4'h1, 8'h46, "R3 page2 ring start readback");
    rd(4'h2, 8'h80, "R3 page2 ring stop readback");
    wr(4'h1, 8'h11);
    wr(4'h0, 8'hE2);
    wr(4'h2, 8'h12);
    see(K_RS, 16'h4600, "R3 page2 write ignored");
    see(K_RE, 16'h8000, "R3 page3 write ignored");
    // R4 fixed values on page 3
    rd(4'h5, 8'h40, "R4 page3 offset 5");
    rd(4'h6, 8'h40, "R4 page3 offset 6");
    rd(4'h3, 8'h00, "R4 page3 offset 3");
    rd(4'h0, 8'hE2, "R1 address 0 is command on page3");
    wr(4'h0, 8'h22);
    rd(4'hA, 8'h50, "R4 page0 id low");
    rd(4'hB, 8'h43, "R4 page0 id high");
    rd(4'hC, 8'h00, "R4 page0 offset C unmapped");
    wr(4'h3, 8'h4C);
    rd(4'h3, 8'h4C, "R4 boundary readback");
    // R5 byte lanes
    wr(4'h8, 8'h34);
    wr(4'h9, 8'h12);
    rd(4'h8, 8'h34, "R5 remote address low");
    rd(4'h9, 8'h12, "R5 remote address high");
    wr(4'h8, 8'h56);
    rd(4'h9, 8'h12, "R5 low write kept high byte");
    rd(4'h8, 8'h56, "R5 low byte replaced");
    // R13 configuration outputs
    wr(4'hC, 8'h0C);
    wr(4'hE, 8'h49);
    see(K_RXC, 16'h000C, "R13 rx_cfg");
    see(K_DMAC, 16'h0049, "R13 dma_cfg");
    // R10 transmit
    wr(4'h4, 8'h40);
    wr(4'h6, 8'h02);
    wr(4'h5, 8'h3C);
    wr(4'hF, 8'h02);
    see(K_TXREQ, 16'h0, "R10 no request before command");
    wr(4'h0, 8'h26);
    push(K_TXREQ, 16'h1, "R10 tx_req pulse");
    push(K_TXADR, 16'h4000, "R10 tx_addr");
    push(K_TXLEN, 16'h023C, "R5 R10 tx_len byte lanes");
    see(K_IRQ, 16'h1, "R6 R10 irq from tx bit");
    see(K_TXREQ, 16'h0, "R10 tx_req lasts one cycle");
    rd(4'h0, 8'h22, "R10 transmit bit cleared");
    rd(4'h4, 8'h01, "R10 transmit status");
    rd(4'h7, 8'h02, "R10 tx status bit");
    // R11 stopped transmit
    wr(4'h7, 8'h02);
    see(K_IRQ, 16'h0, "R7 R6 clear drops irq");
    wr(4'h0, 8'h25);
    see(K_TXREQ, 16'h0, "R11 no request while stopped");
    rd(4'h0, 8'h25, "R11 command kept as written");
    rd(4'h7, 8'h00, "R11 no status change");
    wr(4'h0, 8'h22);
    // R9 DMA-done with zero count
    wr(4'h0, 8'h0A);
    rd(4'h7, 8'h40, "R9 remote read with zero count");
    see(K_IRQ, 16'h0, "R6 bit6 masked");
    wr(4'hF, 8'h40);
    see(K_IRQ, 16'h1, "R6 bit6 unmasked");
    wr(4'h7, 8'h40);
    rd(4'h7, 8'h00, "R7 clear bit6");
    wr(4'hB, 8'h01);
    wr(4'h0, 8'h12);
    rd(4'h7, 8'h00, "R9 nonzero count no set");
    wr(4'hA, 8'h05);
    wr(4'hB, 8'h00);
    wr(4'h0, 8'h0A);
    rd(4'h7, 8'h00, "R5 R9 count low byte kept");
    wr(4'hA, 8'h00);
    wr(4'h0, 8'h12);
    rd(4'h7, 8'h40, "R9 remote write with zero count");
    wr(4'h7, 8'h7F);
    // R7 events and collision
    evt_set = 7'h05;
    step();
    evt_set = 7'h00;
    rd(4'h7, 8'h05, "R7 events set bits");
    addr = 4'h7; wdata = 8'h01; wr_en = 1'b1; evt_set = 7'h01;
    step();
    wr_en = 1'b0; evt_set = 7'h00;
    rd(4'h7, 8'h05, "R7 event wins over clear");
    wr(4'h7, 8'h04);
    rd(4'h7, 8'h01, "R7 clear only written ones");
    wr(4'hF, 8'h01);
    see(K_IRQ, 16'h1, "R6 receive bit raises irq");
    // second reset, reset bit behaviour
    do_reset();
    rd(4'h7, 8'h80, "R12 status after second reset");
    see(K_IRQ, 16'h0, "R12 mask cleared by reset");
    wr(4'h7, 8'hFF);
    rd(4'h7, 8'h80, "R7 reset bit not cleared by status write");
    wr(4'h0, 8'h21);
    rd(4'h7, 8'h80, "R8 stopped command keeps reset bit");
    wr(4'h0, 8'h22);
    rd(4'h7, 8'h00, "R8 running command clears reset bit");
    step();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog all requirements actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule